// File: doc/BRIEF.md
# Load-multiple instruction sequencer

This block carries out one 16-bit load-multiple instruction for a small core that has eight low registers. When the start strobe is high it decodes the instruction word. It reads the base register through a register-file read port and stores that value. It then makes one 32-bit memory read for each register whose bit is set in the 8-bit list. The reads go in ascending register order, each at an address 4 above the last. Each returned word is written into its register.

The base register has no writeback bit in the encoding. The rule is implied by the list itself. If the base's own bit is clear, the block writes the base register with its old value plus four times the number of listed registers. If the base's bit is set, the base ends up holding the word loaded from memory. An instruction with the wrong opcode, or with an empty list, raises the error output and performs no access.

Top module: `ldm_seq`

## Requirements
- R1: The instruction word carries opcode 5'b11001 in bits 15:11, the base register number in bits 10:8 and the register list in bits 7:0 (bit i selects register i). A start whose opcode bits differ makes the block pulse `err` for one cycle, with no memory read and no register write.
- R2: A start whose list bits 7:0 are all zero pulses `err` for one cycle, with no memory read, no register write and no `done`.
- R3: The first read address is the value the base register held when the start was accepted. Each later read address is 4 above the one before.
- R4: `mem_req` is a one-cycle pulse. The next request is not issued until `mem_rvalid` has returned the previous word, so the number of reads equals the number of set list bits.
- R5: Listed registers are loaded in ascending order, r0 first. The word returned by the k-th read is written to the k-th listed register.
- R6: When the base register's list bit is clear, the base register ends with its original value plus 4 times the number of set list bits.
- R7: When the base register's list bit is set, the base register ends with the word loaded for it, and no extra writeback write occurs.
- R8: Loading the base register partway through the sequence does not change the addresses of later reads.
- R9: `done` is high for exactly one cycle. It follows the last register write, or the writeback when there is one.
- R10: A start strobe that arrives while a sequence is in progress is ignored.
- R11: After reset the block is idle, with `mem_req`, `rf_we`, `done` and `err` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a sequence when idle |
| instr | input | 16 | Instruction word, sampled with `start` |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rf_raddr | output | 3 | Register-file read address (base field of `instr`) |
| rf_rdata | input | 32 | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse (bad opcode or empty list) |

## Verification
The bench targets four cases. The first is a base that is listed and gets loaded partway through a sequence. A design that updates its address from the live register would then read the following words from the wrong place. The second is a base that is listed, where a design that writes back anyway would overwrite the loaded word with an incremented address. The third is an unlisted base, where a missing or miscounted writeback leaves the wrong final value. The last covers empty lists and wrong opcodes, which must produce an error with no traffic, and a second start during a busy sequence, which a careless design would act on and so corrupt registers. The memory responds after random delays, and the loaded words depend on the address. This way a skipped, doubled or misordered read shows up in the final register contents.

// File: rtl/ldm_seq.sv
module ldm_seq #(
  parameter int DW = 32,
  parameter int NREG = 8,
  parameter logic [4:0] OPC = 5'b11001
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [15:0]             instr,
  output logic                    mem_req,
  output logic [DW-1:0]           mem_addr,
  input  logic                    mem_rvalid,
  input  logic [DW-1:0]           mem_rdata,
  output logic [$clog2(NREG)-1:0] rf_raddr,
  input  logic [DW-1:0]           rf_rdata,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_waddr,
  output logic [DW-1:0]           rf_wdata,
  output logic                    done,
  output logic                    err
);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_WB, S_DONE, S_ERR} st_t;

  st_t            st;
  logic [NREG-1:0] rem;
  logic [RW-1:0]  base_n;
  logic [DW-1:0]  addr, wb_val;
  logic           wback;
  logic [RW-1:0]  cur;
  logic [CW-1:0]  cnt;
  logic [NREG-1:0] rem_nx;

  wire [NREG-1:0] lst  = instr[NREG-1:0];
  wire            bad  = (instr[15:11] != OPC) || (lst == '0);

  always_comb begin
    cur = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem[i]) cur = RW'(i);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++)
      cnt = cnt + CW'(lst[i]);
  end

  assign rem_nx   = rem & ~(NREG'(1) << cur);
  assign rf_raddr = instr[10:8];
  assign mem_req  = (st == S_REQ);
  assign mem_addr = addr;
  assign rf_we    = (st == S_WAIT && mem_rvalid) || st == S_WB;
  assign rf_waddr = (st == S_WB) ? base_n : cur;
  assign rf_wdata = (st == S_WB) ? wb_val : mem_rdata;
  assign done     = (st == S_DONE);
  assign err      = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rem    <= '0;
      base_n <= '0;
      addr   <= '0;
      wb_val <= '0;
      wback  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            if (bad) st <= S_ERR;
            else begin
              st     <= S_REQ;
              rem    <= lst;
              base_n <= instr[10:8];
              addr   <= rf_rdata;
              wb_val <= rf_rdata + (DW'(cnt) << 2);
              wback  <= !lst[instr[10:8]];
            end
          end
        S_REQ: st <= S_WAIT;
        S_WAIT:
          if (mem_rvalid) begin
            rem  <= rem_nx;
            addr <= addr + DW'(4);
            if (rem_nx == '0) st <= wback ? S_WB : S_DONE;
            else st <= S_REQ;
          end
        S_WB:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req && !rf_we && !done);
  a_r5_write_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && st != S_WB) |-> mem_rvalid);
  a_r7_no_wb_listed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |-> !rem[base_n] && wback);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && mem_rvalid) |=> mem_addr == $past(mem_addr) + DW'(4));
endmodule

// File: tb/tb_ldm_seq.sv
module tb_ldm_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] instr = '0;
  logic mem_req, mem_rvalid = 0, rf_we, done, err;
  logic [31:0] mem_addr, mem_rdata = '0, rf_rdata, rf_wdata;
  logic [2:0] rf_raddr, rf_waddr;
  logic [31:0] rf [8];
  int checks = 0, errors = 0;
  int nreads = 0, nwrites = 0;
  logic pend = 0;
  logic [31:0] paddr;
  int dly;

  always #2.5 clk = ~clk;

  ldm_seq dut (.clk, .rst_n, .start, .instr, .mem_req, .mem_addr, .mem_rvalid,
    .mem_rdata, .rf_raddr, .rf_rdata, .rf_we, .rf_waddr, .rf_wdata, .done, .err);

  assign rf_rdata = rf[rf_raddr];

  function automatic logic [31:0] memf(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0BAD_F00D;
  endfunction

  always @(posedge clk) begin
    if (rf_we) begin rf[rf_waddr] <= rf_wdata; nwrites <= nwrites + 1; end
  end

  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (dly == 0) begin mem_rvalid <= 1'b1; mem_rdata <= memf(paddr); pend <= 0; end
      else dly <= dly - 1;
    end else if (mem_req) begin
      pend <= 1; paddr <= mem_addr; dly <= $urandom % 4; nreads <= nreads + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic run(logic [15:0] ins, bit inject);
    logic [31:0] exp [8];
    logic [31:0] base, a;
    int n, cnt, cyc;
    bit bad, gotd, gote, wb;
    for (int i = 0; i < 8; i++) begin rf[i] = $urandom; exp[i] = rf[i]; end
    n = ins[10:8]; base = rf[n]; a = base; cnt = 0;
    bad = (ins[15:11] != 5'b11001) || (ins[7:0] == 0);
    for (int i = 0; i < 8; i++)
      if (ins[i]) begin exp[i] = memf(a); a += 4; cnt++; end
    wb = !ins[n];
    if (wb) exp[n] = base + 32'(4 * cnt);
    @(negedge clk); nreads = 0; nwrites = 0; instr = ins; start = 1;
    @(negedge clk); start = 0;
    gotd = 0; gote = 0; cyc = 0;
    while (!gotd && !gote && cyc < 300) begin
      if (inject && cyc == 3) begin instr = 16'hC8FF; start = 1; end
      else start = 0;
      if (done) gotd = 1;
      if (err) gote = 1;
      if (!gotd && !gote) begin @(negedge clk); cyc++; end
    end
    start = 0;
    if (cyc >= 300) chk(0, "R9 timeout", 0, 1);
    if (bad) begin
      chk(gote && !gotd, "R1/R2 err pulse", {30'd0, gote, gotd}, 32'd2);
      @(negedge clk);
      chk(!err, "R2 err one cycle", err, 0);
      repeat (4) @(negedge clk);
      chk(nreads == 0 && nwrites == 0, "R2 no traffic (R1 bad opcode)", nreads, 0);
      chk(!done, "R2 no done", done, 0);
    end else begin
      chk(gotd, "R9 done seen", gotd, 1);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      chk(nreads == cnt, "R4 read count", nreads, cnt);
      chk(nwrites == cnt + (wb ? 1 : 0), "R7 write count", nwrites, cnt + (wb ? 1 : 0));
      for (int i = 0; i < 8; i++)
        chk(rf[i] === exp[i], i == n ? (wb ? "R6 base writeback" : "R7 base keeps loaded")
                                     : "R5 R3 R8 R10 loaded value", rf[i], exp[i]);
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) rf[i] = 0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !rf_we && !done && !err, "R11 reset idle",
        {mem_req, rf_we, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !done && !err, "R11 idle after reset", {mem_req, done, err}, 0);
    run(16'hC904, 0);
    run(16'hC902, 0);
    run(16'hC90A, 0);
    run(16'hC9FF, 0);
    run(16'hCF01, 0);
    run(16'hCF80, 0);
    run(16'hC800, 0);
    run(16'h4904, 0);
    run(16'hCA0F, 1);
    for (int k = 0; k < 40; k++) begin
      logic [15:0] w;
      w = {5'b11001, 3'($urandom), 8'($urandom)};
      if (k % 10 == 0) w[7:0] = 0;
      run(w, (k % 3) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule